// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that counts down from the system clock through a two-ratio prescaler into a down-counter whose width is a parameter (15 bits by default, giving 32768 counts). Software must keep it from running out by writing an ordered two-byte unlock sequence to its refresh register. If it runs out, the counter reloads and keeps counting, and the block either pulses an interrupt or raises a sticky reset request, as the control register selects. With a 16 MHz clock, divide-by-16 and the default width, one period is 524288 clocks, or about 32.8 ms.

A configuration input, sampled only while reset is held, decides whether counting begins on its own after reset or waits for software to write the start register. A sleep input freezes the prescaler and the counter, and counting picks up from the held state when sleep drops. The prescaler is cleared only by reset, so a refresh restarts the counter but not the prescaler phase.

Top module: `wdog_timer`

## Requirements
- R1: Control register at address 0: bit 7 picks the prescale ratio (0 = divide by 16, 1 = divide by 128), bit 6 picks the reaction (0 = interrupt, 1 = reset request). Both are 0 after reset. The prescaler makes one tick for every ratio cycles in which counting is enabled.
- R2: The counter starts at its all-ones value, 2^CNT_W-1, and drops by one per tick. The tick that finds it at zero is an underflow. That tick reloads the all-ones value and counting goes on, so successive underflows come 2^CNT_W x ratio counting cycles apart, and the first one comes at the last of the first 2^CNT_W x ratio counting cycles.
- R3: Writing 00h and then FFh to the refresh register at address 1 reloads the all-ones value at the FFh write. Any other write to address 1 clears the sequence: FFh alone, FFh then 00h, or 00h then another value then FFh all do nothing. Writes to other addresses do not disturb a sequence in progress. A refresh takes priority over a tick in the same cycle.
- R4: A refresh leaves the prescaler alone. The next underflow comes on the 2^CNT_W-th tick after the refresh, and the ticks keep the phase they had since counting began.
- R5: cfg_hold_start is sampled only while rst_n is low. At 0, counting begins at the first clock after reset. At 1, the prescaler and counter stay stopped until any write to the start register at address 2, and counting begins at the clock after that write. Changing the input after reset has no effect.
- R6: In interrupt mode, wdt_irq is high for exactly one cycle, starting the cycle after the underflow edge. In reset mode, wdt_rst_req goes high the cycle after the underflow edge and stays high until reset, and wdt_irq stays low.
- R7: While sleep is high, the prescaler and the counter hold their state. When sleep drops, counting continues from that state, so the next underflow is delayed by exactly the number of sleep cycles.
- R8: While rst_n is low and right after it, wdt_irq and wdt_rst_req are 0. A reset clears a raised reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the count source |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hold_start | input | 1 | Start-mode configuration, sampled during reset |
| sleep | input | 1 | Freezes prescaler and counter while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 refresh, 2 start |
| wr_data | input | DW | Register write data |
| wdt_irq | output | 1 | One-cycle watchdog interrupt pulse |
| wdt_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The counter runs with a 4-bit width so that whole periods fit in short runs. A free-running period at divide-by-16 is measured twice, once to time the first underflow from reset and once to check the reload spacing. A held start at divide-by-128 shows that the block stays silent until the start write. Refresh traffic mixes wrong orders, which must leave the expected underflow where it was, with a correct sequence that has a start write inside it and lands in the middle of a prescaler cycle. That case tells a proper reload apart from one that also clears the prescaler. A sleep window must shift the underflow by exactly its length, and a run in reset mode must give a sticky request with no interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned REG_AW = 2;
   localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_KICK  = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_START = 2'd2;
   localparam int unsigned CTRL_DIV_BIT = 7;
   localparam int unsigned CTRL_RST_BIT = 6;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV_LO = 16,
   parameter int unsigned DIV_HI = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_hi,
   output logic tick
);
   localparam int unsigned PW = $clog2(DIV_HI);
   localparam bit POW2 = ((DIV_LO & (DIV_LO - 1)) == 0) && ((DIV_HI & (DIV_HI - 1)) == 0);
   localparam logic [PW-1:0] LAST_LO = PW'(DIV_LO - 1);
   localparam logic [PW-1:0] LAST_HI = PW'(DIV_HI - 1);

   logic [PW-1:0] pcnt;
   logic [PW-1:0] last;
   assign last = sel_hi ? LAST_HI : LAST_LO;

   generate
      if (POW2) begin : g_pow2
         // free-running binary counter; ratio is a mask on its low bits
         always_ff @(posedge clk) begin
            if (!rst_n)   pcnt <= '0;
            else if (run) pcnt <= pcnt + PW'(1);
         end
         assign tick = run && ((pcnt & last) == last);
      end else begin : g_mod
         logic wrap;
         assign wrap = (pcnt >= last);
         always_ff @(posedge clk) begin
            if (!rst_n)   pcnt <= '0;
            else if (run) pcnt <= wrap ? '0 : pcnt + PW'(1);
         end
         assign tick = run && wrap;
      end
   endgenerate
endmodule

// File: rtl/wdog_kick_det.sv
module wdog_kick_det #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kick_wr,
   input  logic [DW-1:0] data,
   output logic          kick
);
   localparam logic [DW-1:0] ARM_VAL  = '0;
   localparam logic [DW-1:0] FIRE_VAL = '1;

   logic armed;

   assign kick = kick_wr && armed && (data == FIRE_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= 1'b0;
      else if (kick_wr) armed <= (data == ARM_VAL);
   end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   output logic [CNT_W-1:0] cnt,
   output logic             uflow
);
   localparam logic [CNT_W-1:0] FULL = '1;

   assign uflow = tick && !reload && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= FULL;
      else if (reload || uflow) cnt <= FULL;
      else if (tick)            cnt <= cnt - CNT_W'(1);
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W  = 15,
   parameter int unsigned DIV_LO = 16,
   parameter int unsigned DIV_HI = 128,
   parameter int unsigned DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hold_start,
   input  logic              sleep,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic              wdt_irq,
   output logic              wdt_rst_req
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("wdog_timer: CNT_W must be at least 2");
      end
      if (DIV_LO < 2 || DIV_HI <= DIV_LO) begin : g_bad_div
         $error("wdog_timer: need 2 <= DIV_LO < DIV_HI");
      end
      if (DW <= CTRL_DIV_BIT) begin : g_bad_dw
         $error("wdog_timer: DW too narrow for control fields");
      end
   endgenerate

   logic run_q, div_hi_q, rst_mode_q, irq_q, rst_req_q;
   logic active, tick, kick, uflow;
   logic wr_ctrl, wr_kick, wr_start;
   logic [CNT_W-1:0] cnt;

   assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_kick  = wr_en && (wr_addr == ADDR_KICK);
   assign wr_start = wr_en && (wr_addr == ADDR_START);
   assign active   = run_q && !sleep;

   wdog_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(active), .sel_hi(div_hi_q), .tick(tick)
   );

   wdog_kick_det #(.DW(DW)) u_kick (
      .clk(clk), .rst_n(rst_n), .kick_wr(wr_kick), .data(wr_data), .kick(kick)
   );

   wdog_downcount #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(kick), .cnt(cnt), .uflow(uflow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= !cfg_hold_start;
         div_hi_q   <= 1'b0;
         rst_mode_q <= 1'b0;
         irq_q      <= 1'b0;
         rst_req_q  <= 1'b0;
      end else begin
         if (wr_start) run_q <= 1'b1;
         if (wr_ctrl) begin
            div_hi_q   <= wr_data[CTRL_DIV_BIT];
            rst_mode_q <= wr_data[CTRL_RST_BIT];
         end
         irq_q <= uflow && !rst_mode_q;
         if (uflow && rst_mode_q) rst_req_q <= 1'b1;
      end
   end

   assign wdt_irq     = irq_q;
   assign wdt_rst_req = rst_req_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input logic             run,
   input logic             tick,
   input logic             kick,
   input logic             rst_mode,
   input logic [CNT_W-1:0] cnt,
   input logic             irq,
   input logic             rst_req
);
   localparam logic [CNT_W-1:0] FULL = '1;

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R6
   AST_IRQ_ONLY_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !$past(rst_mode)); // R6
   AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req); // R6
   AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> (cnt == FULL)); // R3
   AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n) (tick && !kick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2
   AST_UFLOW_RELOADS: assert property (@(posedge clk) disable iff (!rst_n) (tick && !kick && cnt == '0) |=> (cnt == FULL)); // R2
   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (sleep && !kick) |=> $stable(cnt)); // R7
   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(cnt)); // R5
   AST_NO_TICK_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !tick); // R7
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep(sleep), .run(run_q), .tick(tick), .kick(kick),
   .rst_mode(rst_mode_q), .cnt(cnt), .irq(wdt_irq), .rst_req(wdt_rst_req)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
   localparam int CW    = 4;
   localparam int FULLN = 2 ** CW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_hold_start = 1'b0;
   logic       sleep = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       wdt_irq, wdt_rst_req;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int e0 = 0;
   int irq_exp[$];
   int rst_exp[$];
   int exp_v;
   logic rst_prev = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_timer #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_hold_start(cfg_hold_start), .sleep(sleep),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected event cycles as the design produces events
   always @(negedge clk) begin
      if (!rst_n) begin
         rst_prev <= 1'b0;
      end else begin
         if (wdt_irq) begin
            if (irq_exp.size() == 0) chk(1'b0, "R6", "unexpected interrupt at cycle", cyc, -1);
            else begin
               exp_v = irq_exp.pop_front();
               chk(cyc == exp_v, "R2/R6", "interrupt cycle", cyc, exp_v);
            end
         end
         if (wdt_rst_req && !rst_prev) begin
            if (rst_exp.size() == 0) chk(1'b0, "R6", "unexpected reset request at cycle", cyc, -1);
            else begin
               exp_v = rst_exp.pop_front();
               chk(cyc == exp_v, "R6", "reset request cycle", cyc, exp_v);
            end
         end
         rst_prev <= wdt_rst_req;
      end
   end

   task automatic do_reset(input bit hold);
      rst_n = 1'b0;
      wr_en = 1'b0;
      sleep = 1'b0;
      cfg_hold_start = hold;
      irq_exp.delete();
      rst_exp.delete();
      repeat (3) @(negedge clk);
      chk(wdt_irq == 1'b0 && wdt_rst_req == 1'b0, "R8", "outputs in reset",
          int'({wdt_irq, wdt_rst_req}), 0);
      rst_n = 1'b1;
      e0 = cyc + 1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, output int k);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #1 k = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string req);
      chk(irq_exp.size() == 0 && rst_exp.size() == 0, req, "events still pending",
          irq_exp.size() + rst_exp.size(), 0);
   endtask

   // underflow after a refresh at edge k, prescaler phase kept from base
   function automatic int uf_after_kick(input int base, input int r, input int k);
      int m;
      m = (k - base + 1) / r + 1;
      return base + m * r - 1 + (FULLN - 1) * r;
   endfunction

   initial begin
      int k, s;
      idle(2);

      // R1 R2 R5: auto start, default divide by 16, two periods
      do_reset(1'b0);
      cfg_hold_start = 1'b1;              // R5: change after reset is ignored
      irq_exp.push_back(e0 + FULLN * 16 - 1);
      irq_exp.push_back(e0 + 2 * FULLN * 16 - 1);
      idle(560);
      drain("R2 periods at divide by 16");

      // R5 R1: held start, divide by 128
      do_reset(1'b1);
      cfg_hold_start = 1'b0;
      wr(2'd0, 8'h80, k);
      wr(2'd1, 8'h00, k);
      wr(2'd1, 8'hFF, k);
      idle(2300);
      drain("R5 held start stays silent");
      wr(2'd2, 8'h5A, s);
      irq_exp.push_back(s + FULLN * 128);
      idle(2100);
      drain("R1 period at divide by 128");

      // R3 R4: wrong orders do nothing, correct one reloads without prescaler clear
      do_reset(1'b0);
      irq_exp.push_back(e0 + FULLN * 16 - 1);
      idle(20);
      wr(2'd1, 8'hFF, k);
      idle(7);
      wr(2'd1, 8'hFF, k);
      wr(2'd1, 8'h00, k);
      idle(5);
      wr(2'd1, 8'h00, k);
      wr(2'd1, 8'h33, k);
      wr(2'd1, 8'hFF, k);
      idle(260);
      drain("R3 bad orders ignored");
      wr(2'd1, 8'h00, k);
      wr(2'd2, 8'h01, k);
      wr(2'd1, 8'hFF, k);
      irq_exp.push_back(uf_after_kick(e0, 16, k));
      idle(300);
      drain("R4 refresh timing");

      // R7: sleep window shifts the underflow
      do_reset(1'b0);
      idle(50);
      sleep = 1'b1;
      idle(37);
      sleep = 1'b0;
      irq_exp.push_back(e0 + 37 + FULLN * 16 - 1);
      idle(300);
      drain("R7 sleep shift");

      // R6 R8: reset reaction is sticky and gives no interrupt
      do_reset(1'b0);
      wr(2'd0, 8'h40, k);
      rst_exp.push_back(e0 + FULLN * 16 - 1);
      idle(600);
      chk(wdt_rst_req == 1'b1, "R6", "reset request held", int'(wdt_rst_req), 1);
      drain("R6 reset request");
      do_reset(1'b0);
      idle(1);
      chk(wdt_rst_req == 1'b0, "R8", "reset request cleared by reset", int'(wdt_rst_req), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cyc >= 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule